// File: doc/BRIEF.md
# Converter Host Command Sequencer

This block is the host side of a serial link to a multi-channel converter. It drives the four-wire SPI bus as the master. Out of reset it brings the converter to a known state by sending a reset pattern, and it then waits for conversion requests. Each request selects one channel and one data width, and it can enable dump mode. The block writes the communications byte and the mode byte that start one single conversion. It then releases chip select and watches the converter's active-low ready pin. When ready falls, it issues the data-register read command and clocks in the result while sending zero bytes.

In dump mode the converter returns its channel status byte ahead of the data in the same transfer, and the block stores that byte separately. A programmable limit bounds how long the block waits for ready. When the limit expires, the request ends with an error flag and not with a result. The host side sees a one-cycle valid strobe and a busy level. The result and status stay steady from the end of a request until the next request is accepted.

Top module: `cnv_host_seq`

## Requirements
- R1: After reset release the block makes exactly one chip-select-low transfer of five bytes, 0x00 then 0xFF four times. `busy` stays high from reset through the end of this transfer, and a `start` seen before `busy` falls has no effect.
- R2: SCLK idles high and toggles only while CS is low. MOSI changes on the falling edge, MISO is sampled on the rising edge, bytes go MSB first, and every SCLK low phase lasts `SCLK_HALF` clock cycles.
- R3: A `start` accepted while idle produces one transfer of two bytes: 0x38 OR channel, then the mode byte 0x40 OR (dump<<3) OR (wide<<1).
- R4: Once ready is low, one transfer follows: 0x48 OR channel, then zero bytes. There is one status byte if dump is enabled, plus 3 data bytes when wide or 2 when narrow.
- R5: `result` holds the data bytes received MSB first. A narrow result fills bits 15:0 and reads zero in bits 23:16. `status` holds the first read byte in dump mode and reads 0x00 otherwise.
- R6: `valid` is a single-cycle pulse that comes in the cycle `busy` falls at the end of the read transfer. `result` and `status` then stay unchanged until the next accepted `start`.
- R7: `busy` rises with an accepted `start` and stays high until `valid` or the timeout. A `start` seen while busy changes neither the channel used nor the number of transfers. CS is high whenever `busy` is low.
- R8: If `rdy_n` is sampled high on `tmo_lim` consecutive waiting cycles (with `tmo_lim` of at least 1), `tmo_err` rises and `busy` falls in that cycle. No read transfer and no `valid` follow. `tmo_err` clears when the next `start` is accepted.
- R9: If `rdy_n` is low in the last waiting cycle the limit allows, the read proceeds and `tmo_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one single conversion |
| chan | input | CH_W | Channel to convert |
| dump_en | input | 1 | Read the status byte ahead of the data |
| wide_en | input | 1 | 1: 24-bit result, 0: 16-bit result |
| tmo_lim | input | TMO_W | Waiting cycles allowed for ready (at least 1) |
| rdy_n | input | 1 | Converter ready, active low, synchronous to clk |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the converter |
| result | output | 24 | Conversion result |
| status | output | 8 | Channel status byte from dump mode |
| valid | output | 1 | One-cycle result strobe |
| busy | output | 1 | Bring-up or request in progress |
| tmo_err | output | 1 | Ready wait timed out |

## Verification
Ready can fall in the very cycle that the wait limit runs out, so the wait-for-ready and timeout functions meet in one cycle. The bench counts cycles from the rise of chip select after the mode write. It holds ready high for exactly `tmo_lim - 1` cycles in one run and `tmo_lim` cycles in another, with limits of 1 and 6. The outcome is judged at the ports: a read transfer with a valid strobe and no error in the first case, and the error flag with no further transfer in the second. A second overlap, a new `start` during the wait, is judged by the channel in the read command and by the transfer count.

// File: rtl/cnv_seq_pkg.sv
// Package: shared command constants and sequencer state type.
// Assumes the converter's command codes as used by the sequencer.
package cnv_seq_pkg;
    localparam logic [7:0] BOOT_LEAD   = 8'h00;
    localparam logic [7:0] BOOT_ONES   = 8'hFF;
    localparam logic [7:0] CMD_WR_MODE = 8'h38;
    localparam logic [7:0] CMD_RD_DATA = 8'h48;
    localparam logic [7:0] MODE_SINGLE = 8'h40;
    localparam logic [7:0] MODE_DUMP   = 8'h08;
    localparam logic [7:0] MODE_WIDE   = 8'h02;

    typedef enum logic [2:0] {
        ST_BOOT, ST_RST, ST_IDLE, ST_CFG, ST_WAIT, ST_READ
    } seq_state_t;
endpackage

// File: rtl/cnv_spi_byte.sv
// Module: one-byte SPI shifter, SCLK idle high.
// On go it latches tx and drops SCLK, shifting MSB first. MOSI changes on
// the falling edge and MISO is sampled on the rising edge. It pulses done
// after the last high phase. Assumes go only while idle.
module cnv_spi_byte #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done
);
    localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic            act, low;
    logic [HC_W-1:0] hc;
    logic [2:0]      bitn;
    logic [7:0]      sh;

    assign mosi = sh[7];

    // Bit timing, shift-out and sample-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= 1'b0;
            low  <= 1'b0;
            hc   <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
            sclk <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!act) begin
                if (go) begin
                    act  <= 1'b1;
                    sh   <= tx;
                    sclk <= 1'b0;
                    low  <= 1'b1;
                    hc   <= '0;
                    bitn <= 3'd7;
                end
            end else if (hc != HC_W'(HALF - 1)) begin
                hc <= hc + 1'b1;
            end else begin
                hc <= '0;
                if (low) begin
                    sclk <= 1'b1;
                    low  <= 1'b0;
                    rx   <= {rx[6:0], miso};
                end else if (bitn == 3'd0) begin
                    act  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    low  <= 1'b1;
                    bitn <= bitn - 1'b1;
                    sh   <= {sh[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/cnv_rdy_timer.sv
// Module: counts waiting cycles with ready still high.
// expire is high in the lim-th consecutive armed cycle with rdy_n high.
// Assumes lim >= 1 and that the wait ends as soon as rdy_n is low.
module cnv_rdy_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rdy_n,
    input  logic [TMO_W-1:0] lim,
    output logic             expire
);
    logic [TMO_W-1:0] cnt;

    assign expire = arm && rdy_n && (cnt == lim - TMO_W'(1));

    // Wait counter, cleared whenever not armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) cnt <= '0;
        else if (rdy_n)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cnv_host_seq.sv
// Module: host command sequencer for a serial converter.
// Sends the bring-up reset pattern, then serves each start with a mode
// write, a wait for rdy_n low (bounded by tmo_lim) and a data read that
// sends zero bytes. Assumes rdy_n is already synchronous to clk.
module cnv_host_seq
    import cnv_seq_pkg::*;
#(
    parameter int SCLK_HALF = 2,
    parameter int TMO_W     = 16,
    parameter int CH_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  chan,
    input  logic             dump_en,
    input  logic             wide_en,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic             rdy_n,
    input  logic             miso,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    output logic [23:0]      result,
    output logic [7:0]       status,
    output logic             valid,
    output logic             busy,
    output logic             tmo_err
);
    localparam int BIDX_W = 3;

    seq_state_t        st;
    logic [BIDX_W-1:0] bidx, last_idx;
    logic              go_q, cs_q, busy_q, valid_q, err_q;
    logic [CH_W-1:0]   ch_q;
    logic              dump_q, wide_q;
    logic [7:0]        tx_byte, rx_byte, ch_bits;
    logic              byte_done, tmo_fire;
    logic [23:0]       res_q;
    logic [7:0]        stat_q;

    assign ch_bits = 8'(ch_q);
    assign cs_n    = cs_q;
    assign busy    = busy_q;
    assign valid   = valid_q;
    assign tmo_err = err_q;
    assign result  = res_q;
    assign status  = stat_q;

    cnv_spi_byte #(.HALF(SCLK_HALF)) u_byte (
        .clk(clk), .rst_n(rst_n), .go(go_q), .tx(tx_byte), .miso(miso),
        .sclk(sclk), .mosi(mosi), .rx(rx_byte), .done(byte_done)
    );

    cnv_rdy_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .arm(st == ST_WAIT), .rdy_n(rdy_n),
        .lim(tmo_lim), .expire(tmo_fire)
    );

    // Index of the final byte of the current transfer.
    always_comb begin
        case (st)
            ST_RST:  last_idx = BIDX_W'(4);
            ST_CFG:  last_idx = BIDX_W'(1);
            ST_READ: last_idx = BIDX_W'(dump_q) + (wide_q ? BIDX_W'(3) : BIDX_W'(2));
            default: last_idx = '0;
        endcase
    end

    // Byte to send for the current state and byte index.
    always_comb begin
        case (st)
            ST_RST:  tx_byte = (bidx == '0) ? BOOT_LEAD : BOOT_ONES;
            ST_CFG:  tx_byte = (bidx == '0) ? (CMD_WR_MODE | ch_bits)
                             : (MODE_SINGLE | (dump_q ? MODE_DUMP : 8'h00)
                                            | (wide_q ? MODE_WIDE : 8'h00));
            ST_READ: tx_byte = (bidx == '0) ? (CMD_RD_DATA | ch_bits) : 8'h00;
            default: tx_byte = 8'h00;
        endcase
    end

    // Transaction sequencing, capture and handshake outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_BOOT;
            bidx    <= '0;
            go_q    <= 1'b0;
            cs_q    <= 1'b1;
            busy_q  <= 1'b1;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            ch_q    <= '0;
            dump_q  <= 1'b0;
            wide_q  <= 1'b0;
            res_q   <= '0;
            stat_q  <= '0;
        end else begin
            go_q    <= 1'b0;
            valid_q <= 1'b0;
            case (st)
                ST_BOOT: begin
                    st   <= ST_RST;
                    cs_q <= 1'b0;
                    go_q <= 1'b1;
                    bidx <= '0;
                end
                ST_IDLE: begin
                    if (start) begin
                        ch_q   <= chan;
                        dump_q <= dump_en;
                        wide_q <= wide_en;
                        busy_q <= 1'b1;
                        err_q  <= 1'b0;
                        res_q  <= '0;
                        stat_q <= '0;
                        st     <= ST_CFG;
                        cs_q   <= 1'b0;
                        go_q   <= 1'b1;
                        bidx   <= '0;
                    end
                end
                ST_WAIT: begin
                    if (!rdy_n) begin
                        st   <= ST_READ;
                        cs_q <= 1'b0;
                        go_q <= 1'b1;
                        bidx <= '0;
                    end else if (tmo_fire) begin
                        err_q  <= 1'b1;
                        busy_q <= 1'b0;
                        st     <= ST_IDLE;
                    end
                end
                default: begin
                    if (byte_done) begin
                        if (st == ST_READ && bidx != '0) begin
                            if (dump_q && bidx == BIDX_W'(1)) stat_q <= rx_byte;
                            else res_q <= {res_q[15:0], rx_byte};
                        end
                        if (bidx != last_idx) begin
                            bidx <= bidx + 1'b1;
                            go_q <= 1'b1;
                        end else begin
                            cs_q <= 1'b1;
                            case (st)
                                ST_CFG: st <= ST_WAIT;
                                ST_RST: begin
                                    st     <= ST_IDLE;
                                    busy_q <= 1'b0;
                                end
                                default: begin
                                    st      <= ST_IDLE;
                                    busy_q  <= 1'b0;
                                    valid_q <= 1'b1;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/cnv_host_seq_chk.sv
// Module: port-level properties of the sequencer, bound to the top.
// Assumes synchronous active-low reset; all properties are off in reset.
module cnv_host_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic valid,
    input logic busy,
    input logic tmo_err
);
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6
    AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (!busy && $past(busy))); // R6
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n); // R7
    AST_TMO_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> (!valid && !busy)); // R8
    AST_TMO_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_err && !busy) |=> (tmo_err || busy)); // R8
endmodule

bind cnv_host_seq cnv_host_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .valid(valid), .busy(busy), .tmo_err(tmo_err)
);

// File: tb/cnv_host_seq_tb_top.sv
// Bench: drives a behavioural converter model and sweeps every channel,
// dump and width combination, plus timeout boundaries.
module cnv_host_seq_tb_top;
    localparam int HALF  = 2;
    localparam int TMO_W = 16;
    localparam int CH_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CH_W-1:0] chan = '0;
    logic dump_en = 1'b0, wide_en = 1'b0;
    logic [TMO_W-1:0] tmo_lim = 16'd20;
    logic rdy_n = 1'b1;
    logic miso = 1'b0;
    logic sclk, cs_n, mosi, valid, busy, tmo_err;
    logic [23:0] result;
    logic [7:0] status;

    int errs = 0, checks = 0, cycles = 0;

    always #2 clk = ~clk;

    cnv_host_seq #(.SCLK_HALF(HALF), .TMO_W(TMO_W), .CH_W(CH_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan),
        .dump_en(dump_en), .wide_en(wide_en), .tmo_lim(tmo_lim),
        .rdy_n(rdy_n), .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .result(result), .status(status), .valid(valid), .busy(busy),
        .tmo_err(tmo_err)
    );

    // Converter model: byte log of MOSI, MISO from out_vec, edge checks.
    logic cs_p = 1'b1, sclk_p = 1'b1;
    int obit = 0, ibit = 0, nby = 0, lowlen = 0;
    int width_bad = 0, stray_edge = 0, trans_cnt = 0, valid_cnt = 0;
    logic [7:0] sh = '0;
    logic [7:0] log_b [0:7];
    logic [63:0] out_vec = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_p && !cs_n) begin obit = 0; ibit = 0; nby = 0; end
            if (!cs_p && cs_n) trans_cnt++;
            if (cs_n && (sclk != sclk_p)) stray_edge++;
            if (!cs_n && sclk_p && !sclk) begin
                if (obit < 64) miso = out_vec[63 - obit];
                obit++;
                lowlen = 1;
            end else if (!sclk) lowlen++;
            if (!cs_n && !sclk_p && sclk) begin
                if (lowlen != HALF) width_bad++;
                sh = {sh[6:0], mosi};
                ibit++;
                if ((ibit % 8) == 0 && nby < 8) begin log_b[nby] = sh; nby++; end
            end
            if (valid) valid_cnt++;
        end
        cs_p = cs_n;
        sclk_p = sclk;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One single-conversion request with the model answering.
    task automatic conv(input int ch, input bit dmp, input bit wd, input int lim,
                        input int k, input bit exp_tmo, input bit inject);
        logic [7:0] stv, mode_exp;
        logic [23:0] dv, exp_res;
        int t0, v0, nexp;
        stv = 8'(8'h80 + ch * 16 + dmp * 2 + wd);
        dv = 24'(24'h3A5C71 * (ch + 1) + dmp * 24'h111 + wd * 24'h20000);
        exp_res = wd ? dv : {8'h00, dv[15:0]};
        mode_exp = 8'(8'h40 + dmp * 8 + wd * 2);
        if (dmp && wd)  out_vec = {8'h00, stv, dv, 24'h0};
        else if (dmp)   out_vec = {8'h00, stv, dv[15:0], 32'h0};
        else if (wd)    out_vec = {8'h00, dv, 32'h0};
        else            out_vec = {8'h00, dv[15:0], 40'h0};
        nexp = 1 + dmp + (wd ? 3 : 2);
        chan = CH_W'(ch); dump_en = dmp; wide_en = wd;
        tmo_lim = TMO_W'(lim); rdy_n = 1'b1;
        t0 = trans_cnt; v0 = valid_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy && !tmo_err, "R7 busy on start", {busy, tmo_err}, 2'b10);
        while (cs_n) @(negedge clk);
        while (!cs_n) @(negedge clk);
        check(nby == 2, "R3 cfg byte count", nby, 2);
        check(log_b[0] == 8'(8'h38 + ch), "R3 comm byte", log_b[0], 8'(8'h38 + ch));
        check(log_b[1] == mode_exp, "R3 mode byte", log_b[1], mode_exp);
        if (exp_tmo) begin
            repeat (k - 1) @(negedge clk);
            check(!tmo_err && busy, "R8 no early timeout", {tmo_err, busy}, 2'b01);
            @(negedge clk);
            check(tmo_err && !busy && !valid, "R8 timeout", {tmo_err, busy, valid}, 3'b100);
            repeat (20) @(negedge clk);
            check(trans_cnt == t0 + 1, "R8 no read", trans_cnt - t0, 1);
            check(valid_cnt == v0, "R8 no valid", valid_cnt - v0, 0);
        end else begin
            for (int i = 0; i < k; i++) begin
                if (inject && i == 0) begin start = 1'b1; chan = CH_W'((ch + 5) % 8); end
                @(negedge clk);
                start = 1'b0;
            end
            chan = CH_W'(ch);
            rdy_n = 1'b0;
            for (int i = 0; i < 5000 && !valid; i++) @(negedge clk);
            check(valid && !busy, "R6 valid ends busy", {valid, busy}, 2'b10);
            check(result == exp_res, "R5 result", result, exp_res);
            check(status == (dmp ? stv : 8'h00), "R5 status", status, dmp ? stv : 8'h00);
            check(!tmo_err, "R9 no error", tmo_err, 0);
            rdy_n = 1'b1;
            @(negedge clk);
            check(!valid && valid_cnt == v0 + 1, "R6 single pulse", valid_cnt - v0, 1);
            check(trans_cnt == t0 + 2, "R4 transfer count", trans_cnt - t0, 2);
            check(nby == nexp, "R4 read byte count", nby, nexp);
            check(log_b[0] == 8'(8'h48 + ch), "R4 read command", log_b[0], 8'(8'h48 + ch));
            for (int i = 1; i < nexp; i++)
                check(log_b[i] == 8'h00, "R4 zero while reading", log_b[i], 0);
            repeat (6) @(negedge clk);
            check(result == exp_res && status == (dmp ? stv : 8'h00), "R6 outputs hold",
                  result, exp_res);
            if (inject) begin
                repeat (30) @(negedge clk);
                check(trans_cnt == t0 + 2 && !busy, "R7 start ignored while busy",
                      trans_cnt - t0, 2);
            end
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(cs_n && sclk && !valid && busy && !tmo_err, "R1 reset state",
              {cs_n, sclk, valid, busy, tmo_err}, 5'b11010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy, "R1 busy during bring-up", busy, 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(trans_cnt == 1 && nby == 5, "R1 one five-byte transfer", nby, 5);
        check(log_b[0] == 8'h00, "R1 lead byte", log_b[0], 8'h00);
        for (int i = 1; i < 5; i++) check(log_b[i] == 8'hFF, "R1 ones byte", log_b[i], 8'hFF);
        repeat (10) @(negedge clk);
        check(trans_cnt == 1 && !busy, "R1 start ignored in bring-up", trans_cnt, 1);

        for (int c = 0; c < 8; c++)
            for (int m = 0; m < 4; m++)
                conv(c, m[1], m[0], 20, 3 + c, 1'b0, 1'b0);

        conv(2, 1'b0, 1'b0, 100, 4, 1'b0, 1'b1);
        conv(1, 1'b1, 1'b0, 6, 5, 1'b0, 1'b0);   // R9 ready in last cycle
        conv(1, 1'b1, 1'b0, 6, 6, 1'b1, 1'b0);   // R8 one cycle later
        conv(4, 1'b0, 1'b1, 1, 0, 1'b0, 1'b0);   // R9 limit of one
        conv(4, 1'b0, 1'b1, 1, 1, 1'b1, 1'b0);   // R8 limit of one
        conv(6, 1'b1, 1'b1, 20, 2, 1'b0, 1'b0);  // R8 error cleared by start

        check(width_bad == 0, "R2 SCLK low phase", width_bad, 0);
        check(stray_edge == 0, "R2 SCLK idle with CS high", stray_edge, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule